// File: doc/BRIEF.md
# DMA Read Request Splitter

This block lets a bus-mastering device pull a large region of host memory across a PCIe-style link. A single command gives a start address and a total byte count. The block turns it into a stream of memory read request headers. Each header carries an address, a byte length and a tag. The length never exceeds the configured read size limit, and no request spans a 4 KB address page.

Requests go out one per cycle for as long as a tag is free, so several reads are in flight at the same time. Completion headers come back carrying a tag and the number of bytes still owed for that tag. A tag returns to the pool once its last byte has arrived. A malformed completion also returns the tag and raises a sticky error flag.

When every request has been issued and every tag has come home, the block raises a one-cycle done pulse and accepts the next command. Payload data, packet framing and reordering are handled elsewhere.

Top module: `dma_read_splitter`

## Requirements
- R1: After reset `cmd_ready` is 1, and `req_valid`, `done` and `err` are 0.
- R2: The 3-bit `max_rd_code` sets the request size limit to 128 << code bytes for codes 0 to 5 (128 to 4096 bytes). Codes 6 and 7 give 4096 bytes.
- R3: Each request length equals the smallest of three values: the bytes still to request, the size limit, and 4096 minus the low 12 bits of the request address. Consecutive requests are contiguous, and their lengths add up to the command length.
- R4: No request crosses a 4 KB address boundary. A first request that starts inside a page stops exactly at the next page boundary.
- R5: An issued tag is never one that is still outstanding. At most NUM_TAGS requests are outstanding at once. When no tag is free, `req_valid` stays low.
- R6: A completion with `cpl_bytes_left` equal to 0 frees its tag. A completion with a nonzero `cpl_bytes_left` and no error keeps the tag outstanding.
- R7: A completion with `cpl_err` set, or with a tag that is not outstanding, sets `err` and frees that tag. `err` stays set until the next command is accepted, which clears it.
- R8: `done` is high for exactly one cycle, once all requests of a command have been issued and all tags have been freed. `cmd_ready` is high only while no command is active.
- R9: While tags are free, requests issue on consecutive cycles without waiting for any completion. The first request follows one cycle after command acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Total bytes to fetch |
| cmd_ready | output | 1 | Idle, command can be taken |
| max_rd_code | input | 3 | Read size limit code |
| req_valid | output | 1 | Request header issued this cycle |
| req_addr | output | ADDR_W | Request start address |
| req_len | output | 13 | Request length in bytes (1 to 4096) |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | Completion header present |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_bytes_left | input | 13 | Bytes still owed for the tag after this completion |
| cpl_err | input | 1 | Completion carries an error status |
| done | output | 1 | One-cycle transfer-complete pulse |
| err | output | 1 | Sticky completion error flag |

## Verification
The bench starts commands just below a page boundary. A splitter that ignored pages would emit a first request that straddles two pages instead of a short head. With the 4096-byte codes, a decoder that wrapped code 6 or 7 would produce small requests. With completions withheld, the bench checks that issue stops after exactly NUM_TAGS requests; a pool that reused busy tags would keep issuing. Partial completions must not end the transfer early, and error or stray completions must raise the flag and still free the tag, so a wrong release rule either hangs the command or ends it too soon.

// File: rtl/dmars_pkg.sv
package dmars_pkg;

    localparam int PAGE_BYTES = 4096;
    localparam int SZ_W       = 13;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic free_tag;
        logic flag_err;
    } cpl_action_t;

    // Size limit in bytes from the 3-bit code; codes above 5 saturate.
    function automatic logic [SZ_W-1:0] code_to_bytes(input logic [2:0] code);
        logic [SZ_W-1:0] bytes;
        if (code >= 3'd5) bytes = SZ_W'(PAGE_BYTES);
        else              bytes = SZ_W'(128) << code;
        return bytes;
    endfunction

endpackage

// File: rtl/dmars_slicer.sv
module dmars_slicer
    import dmars_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [2:0]        max_code,
    input  logic              advance,
    output logic              pending,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [SZ_W-1:0]   chunk_len
);
    localparam int RW = (LEN_W > SZ_W) ? LEN_W : SZ_W;

    logic [ADDR_W-1:0] addr_q;
    logic [RW-1:0]     rem_q;
    logic [SZ_W-1:0]   page_room;
    logic [SZ_W-1:0]   limit;

    always_comb begin
        page_room = SZ_W'(PAGE_BYTES) - {1'b0, addr_q[11:0]};
        limit     = code_to_bytes(max_code);
        if (page_room < limit) limit = page_room;
        if (rem_q < RW'(limit)) chunk_len = rem_q[SZ_W-1:0];
        else                    chunk_len = limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= RW'(load_len);
        end else if (advance) begin
            addr_q <= addr_q + ADDR_W'(chunk_len);
            rem_q  <= rem_q - RW'(chunk_len);
        end
    end

    assign pending  = (rem_q != '0);
    assign cur_addr = addr_q;

endmodule

// File: rtl/dmars_tag_pool.sv
module dmars_tag_pool #(
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc,
    input  logic                rel_valid,
    input  logic [TAG_W-1:0]    rel_tag,
    output logic [TAG_W-1:0]    free_tag,
    output logic                any_free,
    output logic                all_free,
    output logic [NUM_TAGS-1:0] busy
);
    logic [NUM_TAGS-1:0] busy_q;
    logic [NUM_TAGS-1:0] set_mask;
    logic [NUM_TAGS-1:0] clr_mask;

    // Lowest-numbered free tag.
    always_comb begin
        free_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!busy_q[i]) free_tag = TAG_W'(i);
        end
    end

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (alloc && free_tag == TAG_W'(i))       set_mask[i] = 1'b1;
            if (rel_valid && rel_tag == TAG_W'(i))    clr_mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= (busy_q | set_mask) & ~clr_mask;
    end

    assign any_free = ~&busy_q;
    assign all_free = (busy_q == '0);
    assign busy     = busy_q;

endmodule

// File: rtl/dma_read_splitter.sv
module dma_read_splitter
    import dmars_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int LEN_W    = 24,
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    input  logic [2:0]        max_rd_code,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [12:0]       req_len,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [12:0]       cpl_bytes_left,
    input  logic              cpl_err,
    output logic              done,
    output logic              err
);
    run_state_t          state_q;
    logic                done_q, err_q;
    logic                accept, issue, finish;
    logic                pending, any_free, all_free;
    logic [NUM_TAGS-1:0] busy;
    logic                tag_known;
    cpl_action_t         act;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign issue  = (state_q == ST_RUN) && pending && any_free;
    assign finish = (state_q == ST_RUN) && !pending && all_free;

    dmars_slicer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) slicer_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_addr (cmd_addr),
        .load_len  (cmd_len),
        .max_code  (max_rd_code),
        .advance   (issue),
        .pending   (pending),
        .cur_addr  (req_addr),
        .chunk_len (req_len)
    );

    dmars_tag_pool #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) pool_i (
        .clk       (clk),
        .rst       (rst),
        .alloc     (issue),
        .rel_valid (cpl_valid && act.free_tag),
        .rel_tag   (cpl_tag),
        .free_tag  (req_tag),
        .any_free  (any_free),
        .all_free  (all_free),
        .busy      (busy)
    );

    always_comb begin
        tag_known = 1'b0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (cpl_tag == TAG_W'(i) && busy[i]) tag_known = 1'b1;
        end
        act.flag_err = cpl_valid && (cpl_err || !tag_known);
        act.free_tag = act.flag_err || (cpl_bytes_left == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept)      state_q <= ST_RUN;
            else if (finish) state_q <= ST_IDLE;
            if (accept)       err_q <= 1'b0;
            if (act.flag_err) err_q <= 1'b1;
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign req_valid = issue;
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/dmars_chk.sv
module dmars_chk
    import dmars_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        max_rd_code,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [12:0]       req_len,
    input logic [TAG_W-1:0]  req_tag,
    input logic              cpl_valid,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic [12:0]       cpl_bytes_left,
    input logic              cpl_err,
    input logic              done,
    input logic              err
);
    logic [NUM_TAGS-1:0] shadow_q;
    logic [ADDR_W-1:0]   unused_addr;
    assign unused_addr = req_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else begin
            for (int i = 0; i < NUM_TAGS; i++) begin
                if (cpl_valid && cpl_tag == TAG_W'(i) && (cpl_err || cpl_bytes_left == '0))
                    shadow_q[i] <= 1'b0;
                else if (req_valid && req_tag == TAG_W'(i))
                    shadow_q[i] <= 1'b1;
            end
        end
    end

    // R3
    len_limit_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len != '0) && (req_len <= code_to_bytes(max_rd_code)));

    // R4
    no_page_cross_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ({1'b0, req_addr[11:0]} + req_len <= 13'd4096));

    // R5
    tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !shadow_q[req_tag]);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !(cmd_valid && cmd_ready)) |=> err);

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_err) |=> err);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_drained_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (shadow_q == '0) && !req_valid);

endmodule

bind dma_read_splitter dmars_chk #(
    .ADDR_W(ADDR_W), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)
) chk_i (.*);

// File: tb/dma_read_splitter_tb_top.sv
module dma_read_splitter_tb_top;
    localparam int ADDR_W = 40;
    localparam int LEN_W  = 24;
    localparam int NT     = 8;
    localparam int TW     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic cmd_ready;
    logic [2:0] max_rd_code = 3'd0;
    logic req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [12:0] req_len;
    logic [TW-1:0] req_tag;
    logic cpl_valid = 1'b0;
    logic [TW-1:0] cpl_tag = '0;
    logic [12:0] cpl_bytes_left = '0;
    logic cpl_err = 1'b0;
    logic done, err;

    always #10 clk = ~clk;

    dma_read_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_TAGS(NT)) dut_i (.*);

    typedef struct { longint addr; int len; } exp_t;
    exp_t exp_q[$];
    int ot_tag[$];
    int ot_left[$];

    int checks = 0, errors = 0;
    int cyc = 0, done_cnt = 0, req_seen = 0;
    int first_cyc = -1, last_cyc = -1;
    bit resp_en = 1'b1, prev_done = 1'b0;
    int man_cnt = 0, man_done = 0;
    bit man_front, man_err;
    int man_tag, man_left;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    function automatic int size_of(input int code);
        return (code >= 5) ? 4096 : (128 << code);
    endfunction

    // Driver + responder + monitor, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        cpl_valid = 1'b0;
        cpl_err   = 1'b0;
        if (man_done != man_cnt) begin
            int t;
            t = (man_front && ot_tag.size() > 0) ? ot_tag[0] : man_tag;
            cpl_valid = 1'b1; cpl_tag = TW'(t);
            cpl_bytes_left = 13'(man_left); cpl_err = man_err;
            if (man_front && ot_tag.size() > 0 && (man_left == 0 || man_err)) begin
                void'(ot_tag.pop_front()); void'(ot_left.pop_front());
            end
            man_done++;
        end else if (resp_en && ot_tag.size() > 0) begin
            int piece;
            piece = (ot_left[0] > 256) ? 256 : ot_left[0];
            ot_left[0] -= piece;
            cpl_valid = 1'b1; cpl_tag = TW'(ot_tag[0]);
            cpl_bytes_left = 13'(ot_left[0]);
            if (ot_left[0] == 0) begin
                void'(ot_tag.pop_front()); void'(ot_left.pop_front());
            end
        end
        if (!rst) begin
            if (done) begin
                done_cnt++;
                chk(!prev_done, "R8", "done wider than one cycle", 1, 0);
            end
            prev_done = done;
            if (req_valid) begin
                exp_t e;
                req_seen++;
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected request addr", longint'(req_addr), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(longint'(req_addr) == e.addr, "R3", "request addr", longint'(req_addr), e.addr);
                    chk(int'(req_len) == e.len, "R3/R4", "request len", longint'(req_len), e.len);
                end
                foreach (ot_tag[i])
                    if (ot_tag[i] == int'(req_tag))
                        chk(1'b0, "R5", "tag reused while outstanding", req_tag, -1);
                ot_tag.push_back(int'(req_tag));
                ot_left.push_back(int'(req_len));
                chk(ot_tag.size() <= NT, "R5", "outstanding count", ot_tag.size(), NT);
            end
        end
    end

    task automatic start_cmd(input longint a, input int len, input int code);
        longint p = a;
        int r = len;
        @(negedge clk);
        chk(cmd_ready, "R8", "cmd_ready when idle", cmd_ready, 1);
        while (r > 0) begin
            exp_t e;
            int l = size_of(code);
            int room = 4096 - int'(p % 4096);
            if (room < l) l = room;
            if (r < l) l = r;
            e.addr = p; e.len = l;
            exp_q.push_back(e);
            p += l; r -= l;
        end
        max_rd_code = 3'(code);
        cmd_addr = ADDR_W'(a); cmd_len = LEN_W'(len); cmd_valid = 1'b1;
        first_cyc = -1; req_seen = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        int start = done_cnt;
        int n = 0;
        while (done_cnt == start && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(done_cnt == start + 1, "R8", "done pulse count", done_cnt - start, 1);
        chk(exp_q.size() == 0, rq, "requests left unissued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
    endtask

    task automatic man_cpl(input bit front, input int tag, input int left, input bit e);
        man_front = front; man_tag = tag; man_left = left; man_err = e;
        man_cnt++;
        while (man_done != man_cnt) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
        chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(err == 1'b0, "R1", "err after reset", err, 0);

        // R9: eight 128-byte requests back to back
        start_cmd(40'h1000, 1024, 0);
        wait_done("R3");
        chk(last_cyc - first_cyc == 7, "R9", "issue span cycles", last_cyc - first_cyc, 7);

        // R4: start 64 bytes below a page
        start_cmd(40'h0FC0, 512, 2);
        wait_done("R4");

        // R2/R4: code 7 saturates to 4096, spans pages
        start_cmd(40'h20_0000_0100, 8192, 7);
        wait_done("R2");

        // R2: code 6 gives one 4096-byte request
        start_cmd(40'h0, 4096, 6);
        wait_done("R2");
        chk(req_seen == 1, "R2", "requests for code 6", req_seen, 1);

        // R3: odd tail
        start_cmd(40'h10, 300, 1);
        wait_done("R3");

        // R5: tag exhaustion stalls issue
        resp_en = 1'b0;
        start_cmd(40'h5000, 2048, 0);
        repeat (30) @(negedge clk);
        chk(req_seen == NT, "R5", "requests while tags exhausted", req_seen, NT);
        chk(req_valid == 1'b0, "R5", "req_valid with no free tag", req_valid, 0);
        resp_en = 1'b1;
        wait_done("R5");

        // R6: partial completion keeps the tag
        resp_en = 1'b0;
        start_cmd(40'h3000, 512, 2);
        repeat (3) @(negedge clk);
        man_cpl(1'b1, 0, 256, 1'b0);
        repeat (6) @(negedge clk);
        chk(cmd_ready == 1'b0, "R6", "command still active after partial", cmd_ready, 0);
        man_cpl(1'b1, 0, 0, 1'b0);
        wait_done("R6");

        // R7: error completion flags err and frees the tag
        start_cmd(40'h4000, 128, 0);
        repeat (3) @(negedge clk);
        man_cpl(1'b1, 0, 64, 1'b1);
        @(negedge clk);
        chk(err == 1'b1, "R7", "err after error completion", err, 1);
        wait_done("R7");

        // R7: accepting a command clears err
        resp_en = 1'b1;
        start_cmd(40'h6000, 256, 0);
        chk(err == 1'b0, "R7", "err after new command", err, 0);
        wait_done("R7");

        // R7: stray tag while idle
        resp_en = 1'b0;
        man_cpl(1'b0, 5, 0, 1'b0);
        @(negedge clk);
        chk(err == 1'b1, "R7", "err after unknown tag", err, 1);
        chk(cmd_ready == 1'b1, "R8", "idle after stray completion", cmd_ready, 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule